// File: doc/BRIEF.md
# Serial-Programmed Double-Buffered DAC Code Front End

This block is the digital control side of a single-channel voltage-output converter. A host drives three wires: an active-low select/load strobe, a serial clock and a serial data line. The block oversamples all three with its own system clock. While the strobe is low, it shifts in one data bit on each rising edge of the serial clock. When the strobe returns high, it decodes the 4-bit command held in the most recent 24 bits and executes it.

Two register stages hold the code. A staging register takes new data on a write. An output register drives the converter and changes only on an update. Commands also power the channel down or up and choose whether the supply or the internal reference sets full scale. After a wake-up from power-down, a settle counter holds the settled flag low for a fixed number of cycles. The resolution (8, 10 or 12 bits) is a build-time choice, and so is the reset code (zero or mid-scale).

Top module: `dac_serial_front`

## Requirements
- R1: Bits shift in only while cs_ld_n is low, one bit per rising edge of sck, with the most significant bit first. The level of sck at the falling edge of cs_ld_n does not count as an edge.
- R2: In a 24-bit frame, bits 23:20 carry the command, bits 19:16 are ignored and bits 15:0 carry the data word. The N-bit code occupies data bits 15 down to 16-N, and the low 16-N bits are ignored.
- R3: A 32-bit frame (8 leading filler bits) behaves exactly like its final 24 bits.
- R4: Command 4'b0000 loads the code into the staging register and leaves code_o unchanged.
- R5: Command 4'b0001 copies the staging register to code_o and clears pdown_o.
- R6: Command 4'b0011 loads the code into both registers in one step and clears pdown_o.
- R7: Command 4'b0100 sets pdown_o and leaves both registers unchanged.
- R8: Command 4'b0110 clears ref_supply_o (internal reference) and command 4'b0111 sets it. Commands without a write leave the staging register unchanged.
- R9: Any other command code, and any frame shorter than 24 bits, leaves all state unchanged.
- R10: After reset, code_o and the staging register hold zero (RESET_MID=0) or 2^(N-1) (RESET_MID=1), pdown_o is 0, ref_supply_o is 0 and settled_o is 1.
- R11: settled_o is low while the channel is powered down. After an update clears pdown_o, settled_o stays low for exactly SETTLE_CYCLES clock cycles and then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_ld_n | input | 1 | Select/load strobe; low frames a transfer, rising edge executes the command |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, sampled on rising sck |
| code_o | output | RES_BITS | Active code held in the output register |
| pdown_o | output | 1 | Channel is powered down |
| ref_supply_o | output | 1 | 1 selects the supply as reference, 0 the internal reference |
| settled_o | output | 1 | Output is powered and has settled |

## Verification
A wrong staging register cannot be seen until a later update copies it to code_o. For that reason, every write-only, reference-select, power-down and reserved-code case is followed by an update frame, and the value that reaches the port is compared. A bad shift count or frame-length decision shows up at code_o or pdown_o a few cycles after the strobe rises. A bad settle counter shows at settled_o, which is timed to the exact cycle after a wake-up.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   localparam int FRAME_BITS = 24;
   localparam int CMD_MSB    = 23;
   localparam int DATA_BITS  = 16;

   typedef enum logic [3:0] {
      OP_WRITE     = 4'b0000,
      OP_UPDATE    = 4'b0001,
      OP_WRITE_UPD = 4'b0011,
      OP_PDOWN     = 4'b0100,
      OP_REF_INT   = 4'b0110,
      OP_REF_SUPP  = 4'b0111
   } op_e;
endpackage

// File: rtl/dacfe_sync_edge.sv
module dacfe_sync_edge #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES:0] pipe_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("dacfe_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {(STAGES+1){INIT}};
      else        pipe_q <= {pipe_q[STAGES-1:0], d_i};
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
   assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

   // R1: an edge pulse never lasts more than one cycle
   p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
   import dacfe_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_lvl_i,
   input  logic                  cs_fall_i,
   input  logic                  cs_rise_i,
   input  logic                  sck_rise_i,
   input  logic                  sdi_i,
   output logic [FRAME_BITS-1:0] frame_o,
   output logic                  exec_o
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);

   logic [FRAME_BITS-1:0] shreg_q;
   logic [CNT_W-1:0]      cnt_q, cnt_base;

   assign cnt_base = cs_fall_i ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         exec_o  <= 1'b0;
      end else begin
         exec_o <= cs_rise_i && (cnt_q == CNT_W'(FRAME_BITS));
         if (sck_rise_i && !cs_lvl_i) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], sdi_i};
            cnt_q   <= (cnt_base == CNT_W'(FRAME_BITS)) ? cnt_base : cnt_base + 1'b1;
         end else begin
            cnt_q   <= cnt_base;
         end
      end
   end

   assign frame_o = shreg_q;

   // R3: the bit count saturates at one frame length
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(FRAME_BITS));
   // R1: no shifting while the strobe is high
   p_no_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl_i && !cs_fall_i) |=> $stable(shreg_q));
endmodule

// File: rtl/dacfe_core.sv
module dacfe_core
   import dacfe_pkg::*;
#(
   parameter int RES_BITS      = 12,
   parameter bit RESET_MID     = 1'b0,
   parameter int SETTLE_CYCLES = 2250
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  exec_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic [RES_BITS-1:0]   code_o,
   output logic                  pdown_o,
   output logic                  ref_supply_o,
   output logic                  settled_o
);
   localparam int ST_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [RES_BITS-1:0] RST_CODE =
      RESET_MID ? {1'b1, {(RES_BITS-1){1'b0}}} : '0;

   logic [RES_BITS-1:0] stage_q, dac_q, new_code;
   logic [ST_W-1:0]     settle_q;
   logic                pd_q, refs_q;
   logic [3:0]          op;

   assign op       = frame_i[CMD_MSB -: 4];
   assign new_code = frame_i[DATA_BITS-1 -: RES_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= RST_CODE;
         dac_q    <= RST_CODE;
         pd_q     <= 1'b0;
         refs_q   <= 1'b0;
         settle_q <= '0;
      end else begin
         if (settle_q != '0) settle_q <= settle_q - 1'b1;
         if (exec_i) begin
            case (op)
               OP_WRITE: stage_q <= new_code;
               OP_UPDATE: begin
                  dac_q <= stage_q;
                  pd_q  <= 1'b0;
                  if (pd_q) settle_q <= ST_W'(SETTLE_CYCLES);
               end
               OP_WRITE_UPD: begin
                  stage_q <= new_code;
                  dac_q   <= new_code;
                  pd_q    <= 1'b0;
                  if (pd_q) settle_q <= ST_W'(SETTLE_CYCLES);
               end
               OP_PDOWN:    pd_q   <= 1'b1;
               OP_REF_INT:  refs_q <= 1'b0;
               OP_REF_SUPP: refs_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign code_o       = dac_q;
   assign pdown_o      = pd_q;
   assign ref_supply_o = refs_q;
   assign settled_o    = !pd_q && (settle_q == '0);

   // R9: the output register moves only when a command executes
   p_dac_only_on_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(code_o));
   // R7: entering power-down never disturbs the active code
   p_pd_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown_o) |-> $stable(code_o));
   // R11: a wake-up is never reported as settled in the same cycle
   p_wake_unsettled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdown_o) |-> !settled_o);
   // R8: the reference choice changes only on a command
   p_ref_on_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(ref_supply_o));
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
   import dacfe_pkg::*;
#(
   parameter int RES_BITS      = 12,
   parameter bit RESET_MID     = 1'b0,
   parameter int SETTLE_CYCLES = 2250,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_ld_n,
   input  logic                sck,
   input  logic                sdi,
   output logic [RES_BITS-1:0] code_o,
   output logic                pdown_o,
   output logic                ref_supply_o,
   output logic                settled_o
);
   if (RES_BITS != 8 && RES_BITS != 10 && RES_BITS != 12) begin : g_bad_res
      $error("dac_serial_front: RES_BITS must be 8, 10 or 12");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("dac_serial_front: SETTLE_CYCLES must be positive");
   end

   logic cs_lvl, cs_rise, cs_fall;
   logic sck_lvl, sck_rise, sck_fall;
   logic sdi_lvl, sdi_rise, sdi_fall;
   logic exec;
   logic [FRAME_BITS-1:0] frame;

   dacfe_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs (
      .clk(clk), .rst_n(rst_n), .d_i(cs_ld_n),
      .lvl_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
   dacfe_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck (
      .clk(clk), .rst_n(rst_n), .d_i(sck),
      .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));
   dacfe_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sdi (
      .clk(clk), .rst_n(rst_n), .d_i(sdi),
      .lvl_o(sdi_lvl), .rise_o(sdi_rise), .fall_o(sdi_fall));

   dacfe_shifter u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_lvl_i(cs_lvl), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
      .sck_rise_i(sck_rise), .sdi_i(sdi_lvl),
      .frame_o(frame), .exec_o(exec));

   dacfe_core #(
      .RES_BITS(RES_BITS), .RESET_MID(RESET_MID), .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .exec_i(exec), .frame_i(frame),
      .code_o(code_o), .pdown_o(pdown_o),
      .ref_supply_o(ref_supply_o), .settled_o(settled_o));

   // R10: right after reset the channel is powered on the internal reference
   p_reset_state_r10: assert property (@(posedge clk)
      $rose(rst_n) |-> (!pdown_o && !ref_supply_o && settled_o));
endmodule

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;
   localparam int RB  = 10;
   localparam int SET = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_ld_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic [RB-1:0] code_o;
   logic pdown_o, ref_supply_o, settled_o;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   dac_serial_front #(.RES_BITS(RB), .RESET_MID(1'b1), .SETTLE_CYCLES(SET)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_ld_n(cs_ld_n), .sck(sck), .sdi(sdi),
      .code_o(code_o), .pdown_o(pdown_o), .ref_supply_o(ref_supply_o),
      .settled_o(settled_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [23:0] mk(input logic [3:0] op, input logic [RB-1:0] c);
      return {op, 4'b1010, c, 6'b101101};
   endfunction

   task automatic send(input int nbits, input logic [31:0] w, input logic sck_lvl);
      @(negedge clk);
      sck = sck_lvl;
      clks(2);
      cs_ld_n = 1'b0;
      clks(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         sck = 1'b0; sdi = w[i];
         clks(4);
         sck = 1'b1;
         clks(4);
      end
      sck = 1'b0;
      clks(4);
      cs_ld_n = 1'b1;
      clks(10);
   endtask

   task automatic t_reset;
      chk("R10 code", int'(code_o), 512);
      chk("R10 pdown", int'(pdown_o), 0);
      chk("R10 ref", int'(ref_supply_o), 0);
      chk("R10 settled", int'(settled_o), 1);
   endtask

   task automatic t_write_update;
      send(24, {8'h0, mk(4'b0000, 10'd300)}, 1'b0);
      chk("R4 write leaves code", int'(code_o), 512);
      send(24, {8'h0, mk(4'b0001, 10'd77)}, 1'b0);
      chk("R5 update copies staging R2", int'(code_o), 300);
      send(24, {8'h0, mk(4'b0011, 10'd1023)}, 1'b1);
      chk("R6 write+update R1", int'(code_o), 1023);
   endtask

   task automatic t_frame32;
      send(32, {8'hFF, mk(4'b0011, 10'd5)}, 1'b0);
      chk("R3 32-bit frame", int'(code_o), 5);
   endtask

   task automatic t_reserved_short;
      send(24, {8'h0, mk(4'b1011, 10'd900)}, 1'b0);
      chk("R9 reserved code", int'(code_o), 5);
      send(20, {12'h0, mk(4'b0011, 10'd900) >> 4}, 1'b0);
      chk("R9 short frame", int'(code_o), 5);
      send(24, {8'h0, mk(4'b0001, 10'd0)}, 1'b0);
      chk("R9 staging kept", int'(code_o), 5);
   endtask

   task automatic t_reference;
      send(24, {8'h0, mk(4'b0111, 10'd640)}, 1'b0);
      chk("R8 supply ref", int'(ref_supply_o), 1);
      send(24, {8'h0, mk(4'b0001, 10'd0)}, 1'b0);
      chk("R8 data ignored", int'(code_o), 5);
      send(24, {8'h0, mk(4'b0110, 10'd641)}, 1'b0);
      chk("R8 internal ref", int'(ref_supply_o), 0);
   endtask

   task automatic t_powerdown;
      int n;
      send(24, {8'h0, mk(4'b0000, 10'd700)}, 1'b0);
      send(24, {8'h0, mk(4'b0100, 10'd11)}, 1'b0);
      chk("R7 pdown set", int'(pdown_o), 1);
      chk("R7 code kept", int'(code_o), 5);
      chk("R11 low in pdown", int'(settled_o), 0);
      fork
         send(24, {8'h0, mk(4'b0001, 10'd0)}, 1'b0);
         begin
            while (pdown_o) @(negedge clk);
            n = 0;
            while (!settled_o && n < 1000) begin n++; @(negedge clk); end
            chk("R11 settle cycles", n, SET);
         end
      join
      chk("R5 wake clears pdown", int'(pdown_o), 0);
      chk("R7 staging kept", int'(code_o), 700);
   endtask

   initial begin
      fork
         begin : watchdog
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog expired");
         end
         begin
            clks(5);
            rst_n = 1'b1;
            clks(3);
            t_reset();
            t_write_update();
            t_frame32();
            t_reserved_short();
            t_reference();
            t_powerdown();
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule